// File: doc/BRIEF.md
# Body-Bias LDO Mode Sequencer

This controller chooses between the two operating modes of an adaptive body-bias LDO that supplies one voltage domain. In bypass mode the LDO passes the domain supply straight through. In forward-bias mode it applies forward body bias. Software-visible control bits come in as plain inputs: a management enable, a forward-bias permit, a settling wait count, the operating-point selection and a one-cycle change-request strobe. A low-power indication comes from the domain. The block drives the LDO mode line and reports the settled mode and a busy flag.

When a request arrives while the sequencer is idle, it decides the target mode from the inputs present in that cycle. It drives the LDO mode line to that target and then holds a transition state for the programmed number of system clock cycles. The mode status output updates only after that. Requests that arrive during a transition are dropped. When the decided mode equals the current one, the sequencer passes through a single transition cycle and returns to idle.

Top module: `bbias_mode_seq`

## Requirements
- R1: After a synchronous active-low reset, `ldo_mode_o`, `mode_stat_o` and `busy_o` are all 0. Mode encoding: 0 is bypass, 1 is forward bias.
- R2: A request taken while idle selects forward bias (1) when `mgmt_en`, `fbb_permit` and "`opp_sel` equals parameter `OPP_TOP` (default 3'd4)" all hold and `lowpwr` is 0, sampled in the request cycle.
- R3: A request taken with `opp_sel` different from `OPP_TOP` selects bypass (0).
- R4: A request taken with `lowpwr` high selects bypass, whatever the operating point is.
- R5: A request taken with `mgmt_en` low or with `fbb_permit` low selects bypass, even at `OPP_TOP`.
- R6: After the clock edge that takes a request, `ldo_mode_o` equals the selected mode and `busy_o` is 1.
- R7: When the selected mode differs from the current mode, `busy_o` stays 1 for `settle_cnt`+1 cycles. Then it drops, and `mode_stat_o` equals the new mode in that same cycle.
- R8: A `settle_cnt` of 0 ends the transition after one busy cycle.
- R9: When the selected mode equals the current mode, `busy_o` is high for exactly one cycle, whatever `settle_cnt` is.
- R10: A `chg_req` pulse seen while `busy_o` is 1 changes neither `ldo_mode_o` nor the length of the transition in progress.
- R11: While idle with `chg_req` low, changes on the other inputs leave `ldo_mode_o`, `mode_stat_o` and `busy_o` unchanged. When idle, `mode_stat_o` equals `ldo_mode_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mgmt_en | input | 1 | Body-bias management enable |
| fbb_permit | input | 1 | Allows forward-bias mode |
| settle_cnt | input | CNT_W | Settling wait in clock cycles |
| opp_sel | input | OPP_W | Requested operating point |
| chg_req | input | 1 | One-cycle change-request strobe |
| lowpwr | input | 1 | Domain is in a low-power state |
| ldo_mode_o | output | 1 | Mode line to the LDO (1 = forward bias) |
| mode_stat_o | output | 1 | Settled LDO mode |
| busy_o | output | 1 | Transition in progress |

## Verification
The bench builds the block with `CNT_W` = 5 and the default `OPP_TOP` of 4. With a 5-bit count, the longest wait of 31 cycles lies within reach, so a full-scale count runs to its end alongside the zero wait. Because `OPP_W` stays at 3, operating points above the top encoding (5 to 7) are also driven. This shows that only an exact match selects forward bias.

// File: rtl/bbias_pkg.sv
package bbias_pkg;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_SETTLE = 1'b1
  } seq_state_t;

  // Decision rule for the LDO mode: forward bias only when every
  // permission holds and the domain is active.
  function automatic logic want_fbb(input logic en, input logic permit,
                                    input logic at_top, input logic lp);
    return en & permit & at_top & ~lp;
  endfunction

endpackage

// File: rtl/bbias_target.sv
module bbias_target #(
  parameter int OPP_W   = 3,
  parameter int OPP_TOP = 4
) (
  input  logic             mgmt_en,
  input  logic             fbb_permit,
  input  logic [OPP_W-1:0] opp_sel,
  input  logic             lowpwr,
  output logic             fbb_go
);
  import bbias_pkg::*;

  localparam logic [OPP_W-1:0] TopCode = OPP_W'(OPP_TOP);

  logic at_top;
  assign at_top = (opp_sel == TopCode);
  assign fbb_go = want_fbb(mgmt_en, fbb_permit, at_top, lowpwr);

endmodule

// File: rtl/bbias_settle_cnt.sv
module bbias_settle_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             is_zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load)                 cnt_q <= load_val;
    else if (dec && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign is_zero = (cnt_q == '0);

  // R8
  cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && is_zero && !load) |=> is_zero);

endmodule

// File: rtl/bbias_mode_seq.sv
module bbias_mode_seq #(
  parameter int OPP_W   = 3,
  parameter int OPP_TOP = 4,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mgmt_en,
  input  logic             fbb_permit,
  input  logic [CNT_W-1:0] settle_cnt,
  input  logic [OPP_W-1:0] opp_sel,
  input  logic             chg_req,
  input  logic             lowpwr,
  output logic             ldo_mode_o,
  output logic             mode_stat_o,
  output logic             busy_o
);
  import bbias_pkg::*;

  seq_state_t       state_q;
  logic             ldo_q;
  logic             stat_q;
  logic             fbb_go;
  logic             same_mode;
  logic             start_ev;
  logic             finish_ev;
  logic             in_settle;
  logic             cnt_zero;
  logic [CNT_W-1:0] wait_load;

  bbias_target #(.OPP_W(OPP_W), .OPP_TOP(OPP_TOP)) u_tgt (
    .mgmt_en    (mgmt_en),
    .fbb_permit (fbb_permit),
    .opp_sel    (opp_sel),
    .lowpwr     (lowpwr),
    .fbb_go     (fbb_go)
  );

  assign in_settle = (state_q == ST_SETTLE);
  assign start_ev  = (state_q == ST_IDLE) && chg_req;
  assign same_mode = (fbb_go == ldo_q);
  assign wait_load = same_mode ? '0 : settle_cnt;
  assign finish_ev = in_settle && cnt_zero;

  bbias_settle_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_ev),
    .load_val (wait_load),
    .dec      (in_settle),
    .is_zero  (cnt_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ldo_q   <= 1'b0;
      stat_q  <= 1'b0;
    end else begin
      if (start_ev) begin
        state_q <= ST_SETTLE;
        ldo_q   <= fbb_go;
      end else if (finish_ev) begin
        state_q <= ST_IDLE;
        stat_q  <= ldo_q;
      end
    end
  end

  assign ldo_mode_o  = ldo_q;
  assign mode_stat_o = stat_q;
  assign busy_o      = in_settle;

  // R6
  busy_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> busy_o);

  // R10
  ldo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_ev |=> $stable(ldo_mode_o));

  // R5
  fbb_needs_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && !(mgmt_en && fbb_permit)) |=> !ldo_mode_o);

  // R4
  lowpwr_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && lowpwr) |=> !ldo_mode_o);

  // R11
  idle_status_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (mode_stat_o == ldo_mode_o));

  // R9
  same_mode_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && same_mode) |=> busy_o ##1 !busy_o);

endmodule

// File: tb/sim_bbias_mode_seq.sv
module sim_bbias_mode_seq;
  localparam int OPP_W = 3;
  localparam int TOP   = 4;
  localparam int CW    = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mgmt_en = 1'b0, fbb_permit = 1'b0, chg_req = 1'b0, lowpwr = 1'b0;
  logic [CW-1:0] settle_cnt = '0;
  logic [OPP_W-1:0] opp_sel = '0;
  logic ldo_mode_o, mode_stat_o, busy_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic cur_mode = 1'b0;

  always #2 clk = ~clk;

  bbias_mode_seq #(.OPP_W(OPP_W), .OPP_TOP(TOP), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .mgmt_en(mgmt_en), .fbb_permit(fbb_permit),
    .settle_cnt(settle_cnt), .opp_sel(opp_sel), .chg_req(chg_req),
    .lowpwr(lowpwr), .ldo_mode_o(ldo_mode_o), .mode_stat_o(mode_stat_o),
    .busy_o(busy_o));

  function automatic logic model_mode(logic en, logic pm, logic [OPP_W-1:0] op, logic lp);
    if (!en || !pm || lp) return 1'b0;
    return (op == OPP_W'(TOP));
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic request(string req, logic en, logic pm, logic [OPP_W-1:0] op,
                         logic lp, logic [CW-1:0] w);
    logic tgt;
    int exp_len;
    int len;
    tgt = model_mode(en, pm, op, lp);
    exp_len = (tgt == cur_mode) ? 1 : int'(w) + 1;
    @(negedge clk);
    mgmt_en = en; fbb_permit = pm; opp_sel = op; lowpwr = lp;
    settle_cnt = w; chg_req = 1'b1;
    @(negedge clk);
    chk({req, " R6 busy"}, busy_o, 1);
    chk({req, " R6 ldo"}, ldo_mode_o, tgt);
    // R10: a second strobe while busy, aimed at the opposite mode
    mgmt_en = 1'b1; fbb_permit = 1'b1; opp_sel = OPP_W'(TOP);
    lowpwr = tgt; settle_cnt = ~w;
    len = 1;
    @(negedge clk);
    chg_req = 1'b0;
    while (busy_o && len < 100) begin
      chk("R10 ldo held", ldo_mode_o, tgt);
      len++;
      @(negedge clk);
    end
    chk({req, " R7/R8/R9 length"}, len, exp_len);
    chk({req, " R7 status"}, mode_stat_o, tgt);
    cur_mode = tgt;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ldo", ldo_mode_o, 0);
    chk("R1 status", mode_stat_o, 0);
    chk("R1 busy", busy_o, 0);

    request("R2 fbb", 1, 1, 3'd4, 0, 5'd3);
    request("R9 same", 1, 1, 3'd4, 0, 5'd20);
    request("R3 opp5", 1, 1, 3'd5, 0, 5'd0);
    request("R2 fbb max", 1, 1, 3'd4, 0, 5'd31);
    request("R4 lowpwr", 1, 1, 3'd4, 1, 5'd2);
    request("R2 fbb", 1, 1, 3'd4, 0, 5'd0);
    request("R5 en", 0, 1, 3'd4, 0, 5'd1);
    request("R2 fbb", 1, 1, 3'd4, 0, 5'd1);
    request("R5 permit", 1, 0, 3'd4, 0, 5'd4);
    request("R8 same zero", 1, 0, 3'd4, 0, 5'd0);

    // R11: input churn while idle without a request
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      mgmt_en = 1'($urandom); fbb_permit = 1'($urandom);
      opp_sel = OPP_W'($urandom); lowpwr = 1'($urandom);
      settle_cnt = CW'($urandom);
      @(negedge clk);
      chk("R11 ldo", ldo_mode_o, cur_mode);
      chk("R11 status", mode_stat_o, cur_mode);
      chk("R11 busy", busy_o, 0);
    end

    for (int i = 0; i < 60; i++) begin
      logic [OPP_W-1:0] op;
      op = ($urandom % 2) ? OPP_W'(TOP) : OPP_W'($urandom);
      request("R2-rand", ($urandom % 4) != 0, ($urandom % 4) != 0, op,
              ($urandom % 4) == 0, CW'($urandom % 8));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule